// File: doc/BRIEF.md
# Variable-Page-Size Fully Associative Translation Buffer

This block holds a fixed set of address translations and answers one lookup per cycle. Each slot pairs a virtual page tag and a 13-bit address-space identifier with a physical frame and attributes. The attributes are page size, valid, shared-across-contexts, supervisor-only, writable, has-side-effects, speculative-only and byte-swap. Every slot compares its own tag under a mask set by its own page size. Four sizes are supported: 8 KB, 64 KB, 512 KB and 4 MB. The lowest-numbered matching slot supplies the translation.

A lookup presents a 64-bit virtual address, the current context, the access kind and whether the requester runs in user mode. One cycle later the block reports exactly one of three results: a hit with a 41-bit physical address and permissions, a miss, or a fault with one or more cause bits. Instruction fetches issued while a trap is being serviced are translated in context 0 instead of the supplied context. On every miss or fault, a tag-capture register records the faulting page and context so that a refill or fault handler can read them. Slots are loaded through a write port by index. The choice of slot and the refill itself belong to the surrounding logic.

Top module: `vpt_tlb`

## Requirements
- R1: After reset every slot is invalid, no slot is marked used, `tag_capture` is zero and `rsp_valid` is low, so the first lookup misses.
- R2: A request sampled at a clock edge produces `rsp_valid` at that same edge, so the result is visible in the following cycle. With `rsp_valid` high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high. With it low, all three are low.
- R3: Size code 0/1/2/3 selects a page of 8 KB/64 KB/512 KB/4 MB, that is 13+3·code offset bits. A slot matches when the virtual address bits above that offset equal the stored tag bits above it. The physical address takes the frame bits above the offset from the slot and the offset bits from the virtual address, is 41 bits wide, and has bits 12:0 forced to zero.
- R4: A slot matches only when its 13-bit context equals the lookup context, unless the slot is marked shared. A shared slot matches under any context.
- R5: Access kinds are encoded 0 = load, 1 = store, 2 = instruction fetch, 3 = speculative load. A fetch uses context 0 when `req_trap` is high and `req_ctx` otherwise. Data accesses always use `req_ctx`.
- R6: When several slots match, the lowest index wins, and `rsp_entry` reports it on a hit or a fault.
- R7: Fault cause bits in `rsp_cause` are bit0 for a supervisor-only page accessed in user mode (any kind), bit1 for a speculative load to a side-effect page, and bit2 for a load or store to a speculative-only page. Several of these bits may be set in one response.
- R8: Bit3 of `rsp_cause` flags a store to a non-writable page. It is raised only when bits 2:0 are all clear.
- R9: On a data hit, read is granted, write follows the writable attribute, execute is clear, and `rsp_swap` copies the byte-swap attribute. On a fetch hit, only execute is granted. On a miss or a fault, all permissions, `rsp_swap` and `rsp_paddr` are zero.
- R10: A hit sets the used flag of the winning slot. A fault does not set it. Loading a slot clears its used flag.
- R11: On a miss or a fault, `tag_capture` becomes the virtual address with bits 12:0 replaced by the lookup context. On a hit it keeps its value.
- R12: A slot loaded with `wr_valid` low never matches. A load fully replaces the slot's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load one slot |
| wr_idx | input | 6 | Slot to load |
| wr_vaddr | input | 64 | Virtual page address for the slot |
| wr_ctx | input | 13 | Context of the slot |
| wr_paddr | input | 41 | Physical frame address for the slot |
| wr_size | input | 2 | Page size code |
| wr_valid | input | 1 | Slot valid |
| wr_global | input | 1 | Shared across contexts |
| wr_priv | input | 1 | Supervisor-only |
| wr_writable | input | 1 | Writes allowed |
| wr_side_eff | input | 1 | Page has side effects |
| wr_spec_only | input | 1 | Speculative-access-only page |
| wr_swap | input | 1 | Byte-swap accesses to this page |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 64 | Virtual address |
| req_ctx | input | 13 | Current context |
| req_kind | input | 2 | Access kind (R5 encoding) |
| req_user | input | 1 | Requester in user mode |
| req_trap | input | 1 | Trap level is nonzero |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Translation granted |
| rsp_miss | output | 1 | No slot matched |
| rsp_fault | output | 1 | Slot matched but access refused |
| rsp_cause | output | 4 | Fault cause bits (R7, R8) |
| rsp_paddr | output | 41 | Translated physical address |
| rsp_entry | output | 6 | Index of the winning slot |
| rsp_perm_r | output | 1 | Read permission |
| rsp_perm_w | output | 1 | Write permission |
| rsp_perm_x | output | 1 | Execute permission |
| rsp_swap | output | 1 | Byte-swap this access |
| tag_capture | output | 64 | Page and context of the last miss or fault |
| used_flags | output | 64 | Per-slot used flags |

## Verification
Two situations are hard to reach from the ports. The first is several matching slots of different page sizes, where a larger page at a lower index must shadow a smaller one. The second is a single access that trips two fault causes at once while the protection cause stays suppressed. The stimulus loads overlapping slots on purpose, including a 4 MB page below an 8 KB page inside it and a page that is supervisor-only and side-effect at the same time. It then issues user-mode speculative loads and kernel-mode stores against them. Addresses one byte past each page size boundary check that the mask really follows the slot's size code.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

  // Page size step: each size code adds this many offset bits.
  localparam int SZ_STEP = 3;

  typedef enum logic [1:0] {
    ACC_LOAD   = 2'd0,
    ACC_STORE  = 2'd1,
    ACC_FETCH  = 2'd2,
    ACC_SPEC   = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic [1:0] size;
    logic       glob;
    logic       priv;
    logic       wr_ok;
    logic       side_eff;
    logic       spec_only;
    logic       swap;
  } slot_attr_t;

  // Cause bit positions in the fault vector.
  localparam int CB_PRIV = 0;
  localparam int CB_SPEC_SE = 1;
  localparam int CB_SPEC_ONLY = 2;
  localparam int CB_PROT = 3;
  localparam int CAUSE_W = 4;

endpackage

// File: rtl/vpt_match_cell.sv
module vpt_match_cell
  import vpt_pkg::*;
#(
  parameter int VPN_W = 51,
  parameter int CTX_W = 13
) (
  input  logic             slot_valid,
  input  logic [VPN_W-1:0] slot_vpn,
  input  logic [CTX_W-1:0] slot_ctx,
  input  slot_attr_t       slot_attr,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic [CTX_W-1:0] look_ctx,
  output logic             match
);

  logic [VPN_W-1:0] keep;
  logic             vpn_eq;
  logic             ctx_ok;

  // Bits of the page number that lie inside the page offset are ignored.
  always_comb begin
    for (int i = 0; i < VPN_W; i++) begin
      keep[i] = (i >= SZ_STEP * int'(slot_attr.size));
    end
  end

  assign vpn_eq = (((slot_vpn ^ look_vpn) & keep) == '0);
  assign ctx_ok = slot_attr.glob || (slot_ctx == look_ctx);
  assign match  = slot_valid && ctx_ok && vpn_eq;

endmodule

// File: rtl/vpt_first_hit.sv
module vpt_first_hit #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  hits,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Scan from the top so the lowest set bit is the last one written.
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/vpt_access_check.sv
module vpt_access_check
  import vpt_pkg::*;
(
  input  slot_attr_t         attr,
  input  acc_kind_e          kind,
  input  logic               user,
  output logic [CAUSE_W-1:0] cause,
  output logic               perm_r,
  output logic               perm_w,
  output logic               perm_x,
  output logic               swap
);

  logic is_fetch, is_spec, is_store;
  logic c_priv, c_spec_se, c_spec_only, c_prot;

  assign is_fetch = (kind == ACC_FETCH);
  assign is_spec  = (kind == ACC_SPEC);
  assign is_store = (kind == ACC_STORE);

  assign c_priv      = attr.priv && user;
  assign c_spec_se   = is_spec && attr.side_eff;
  assign c_spec_only = !is_fetch && !is_spec && attr.spec_only;
  // Protection is only a fallback when no other cause fired.
  assign c_prot      = is_store && !attr.wr_ok && !(c_priv || c_spec_se || c_spec_only);

  always_comb begin
    cause = '0;
    cause[CB_PRIV]      = c_priv;
    cause[CB_SPEC_SE]   = c_spec_se;
    cause[CB_SPEC_ONLY] = c_spec_only;
    cause[CB_PROT]      = c_prot;
  end

  assign perm_r = !is_fetch;
  assign perm_w = !is_fetch && attr.wr_ok;
  assign perm_x = is_fetch;
  assign swap   = !is_fetch && attr.swap;

endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
  import vpt_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int VA_W     = 64,
  parameter int PA_W     = 41,
  parameter int CTX_W    = 13,
  parameter int PG_SHIFT = 13,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int VPN_W = VA_W - PG_SHIFT,
  localparam int PPN_W = PA_W - PG_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VA_W-1:0]    wr_vaddr,
  input  logic [CTX_W-1:0]   wr_ctx,
  input  logic [PA_W-1:0]    wr_paddr,
  input  logic [1:0]         wr_size,
  input  logic               wr_valid,
  input  logic               wr_global,
  input  logic               wr_priv,
  input  logic               wr_writable,
  input  logic               wr_side_eff,
  input  logic               wr_spec_only,
  input  logic               wr_swap,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [CTX_W-1:0]   req_ctx,
  input  logic [1:0]         req_kind,
  input  logic               req_user,
  input  logic               req_trap,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic               rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [IDX_W-1:0]   rsp_entry,
  output logic               rsp_perm_r,
  output logic               rsp_perm_w,
  output logic               rsp_perm_x,
  output logic               rsp_swap,
  output logic [VA_W-1:0]    tag_capture,
  output logic [ENTRIES-1:0] used_flags
);

  // Slot storage: tag, frame and attribute arrays carry no reset,
  // only the valid and used vectors do.
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [CTX_W-1:0]   ctx_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  slot_attr_t         attr_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] used_q;

  slot_attr_t wr_attr;
  assign wr_attr = '{size: wr_size, glob: wr_global, priv: wr_priv,
                     wr_ok: wr_writable, side_eff: wr_side_eff,
                     spec_only: wr_spec_only, swap: wr_swap};

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= wr_vaddr[VA_W-1:PG_SHIFT];
      ctx_q[wr_idx]  <= wr_ctx;
      ppn_q[wr_idx]  <= wr_paddr[PA_W-1:PG_SHIFT];
      attr_q[wr_idx] <= wr_attr;
    end
  end

  // Lookup context: fetches during trap handling use context zero.
  acc_kind_e        kind;
  logic [CTX_W-1:0] look_ctx;
  logic [VPN_W-1:0] look_vpn;

  assign kind     = acc_kind_e'(req_kind);
  assign look_ctx = (kind == ACC_FETCH && req_trap) ? '0 : req_ctx;
  assign look_vpn = req_vaddr[VA_W-1:PG_SHIFT];

  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
    vpt_match_cell #(.VPN_W(VPN_W), .CTX_W(CTX_W)) u_cell (
      .slot_valid (valid_q[g]),
      .slot_vpn   (vpn_q[g]),
      .slot_ctx   (ctx_q[g]),
      .slot_attr  (attr_q[g]),
      .look_vpn   (look_vpn),
      .look_ctx   (look_ctx),
      .match      (hit_vec[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] win;

  vpt_first_hit #(.N(ENTRIES)) u_pick (
    .hits (hit_vec),
    .any  (any_hit),
    .idx  (win)
  );

  slot_attr_t         w_attr;
  logic [PPN_W-1:0]   w_ppn;
  logic [CAUSE_W-1:0] cause;
  logic               p_r, p_w, p_x, p_swap;
  logic               faulted;

  assign w_attr = attr_q[win];
  assign w_ppn  = ppn_q[win];

  vpt_access_check u_chk_acc (
    .attr   (w_attr),
    .kind   (kind),
    .user   (req_user),
    .cause  (cause),
    .perm_r (p_r),
    .perm_w (p_w),
    .perm_x (p_x),
    .swap   (p_swap)
  );

  assign faulted = |cause;

  // Frame bits inside the page offset come from the virtual address.
  logic [PPN_W-1:0] pa_ppn;
  logic [PA_W-1:0]  pa_full;
  always_comb begin
    for (int i = 0; i < PPN_W; i++) begin
      pa_ppn[i] = (i >= SZ_STEP * int'(w_attr.size)) ? w_ppn[i]
                                                     : req_vaddr[PG_SHIFT + i];
    end
    pa_full = '0;
    pa_full[PA_W-1:PG_SHIFT] = pa_ppn;
  end

  logic [VA_W-1:0] capture_val;
  always_comb begin
    capture_val = '0;
    capture_val[VA_W-1:PG_SHIFT] = look_vpn;
    capture_val[CTX_W-1:0] = look_ctx;
  end

  logic grant;
  assign grant = req_valid && any_hit && !faulted;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= '0;
      used_q      <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_miss    <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_cause   <= '0;
      rsp_paddr   <= '0;
      rsp_entry   <= '0;
      rsp_perm_r  <= 1'b0;
      rsp_perm_w  <= 1'b0;
      rsp_perm_x  <= 1'b0;
      rsp_swap    <= 1'b0;
      tag_capture <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= grant;
      rsp_miss   <= req_valid && !any_hit;
      rsp_fault  <= req_valid && any_hit && faulted;
      rsp_cause  <= (req_valid && any_hit) ? cause : '0;
      rsp_paddr  <= grant ? pa_full : '0;
      rsp_entry  <= (req_valid && any_hit) ? win : '0;
      rsp_perm_r <= grant && p_r;
      rsp_perm_w <= grant && p_w;
      rsp_perm_x <= grant && p_x;
      rsp_swap   <= grant && p_swap;
      if (req_valid && (!any_hit || faulted)) tag_capture <= capture_val;
      if (grant) used_q[win] <= 1'b1;
      // A load in the same cycle overrides the used update.
      if (wr_en) begin
        used_q[wr_idx]  <= 1'b0;
        valid_q[wr_idx] <= wr_valid;
      end
    end
  end

  assign used_flags = used_q;

endmodule

// File: rtl/vpt_tlb_chk.sv
module vpt_tlb_chk #(
  parameter int VA_W = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_fault,
  input logic [3:0]      rsp_cause,
  input logic            rsp_perm_r,
  input logic            rsp_perm_w,
  input logic            rsp_perm_x,
  input logic [VA_W-1:0] tag_capture
);

  assert_one_result_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_fault_cause_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_cause != 4'b0000));

  assert_no_cause_otherwise_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit || rsp_miss) |-> (rsp_cause == 4'b0000));

  assert_prot_alone_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_cause[3] |-> (rsp_cause[2:0] == 3'b000));

  assert_perm_kind_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_perm_x != rsp_perm_r));

  assert_no_perm_on_refusal_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_miss || rsp_fault) |-> !(rsp_perm_r || rsp_perm_w || rsp_perm_x));

  assert_capture_only_on_refusal_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(tag_capture) |-> (rsp_miss || rsp_fault));

endmodule

bind vpt_tlb vpt_tlb_chk #(.VA_W(VA_W)) u_vpt_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_miss    (rsp_miss),
  .rsp_fault   (rsp_fault),
  .rsp_cause   (rsp_cause),
  .rsp_perm_r  (rsp_perm_r),
  .rsp_perm_w  (rsp_perm_w),
  .rsp_perm_x  (rsp_perm_x),
  .tag_capture (tag_capture)
);

// File: tb/tb_vpt_tlb.sv
module tb_vpt_tlb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_vaddr = '0;
  logic [12:0] wr_ctx = '0;
  logic [40:0] wr_paddr = '0;
  logic [1:0]  wr_size = '0;
  logic        wr_valid = 1'b0, wr_global = 1'b0, wr_priv = 1'b0, wr_writable = 1'b0;
  logic        wr_side_eff = 1'b0, wr_spec_only = 1'b0, wr_swap = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [12:0] req_ctx = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0, req_trap = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [3:0]  rsp_cause;
  logic [40:0] rsp_paddr;
  logic [5:0]  rsp_entry;
  logic        rsp_perm_r, rsp_perm_w, rsp_perm_x, rsp_swap;
  logic [63:0] tag_capture;
  logic [63:0] used_flags;

  always #5 clk = ~clk;

  vpt_tlb dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic        hit, miss, fault, swap, pr, pw, px;
    logic [3:0]  cause;
    logic [40:0] pa;
    logic [5:0]  entry;
    logic [63:0] cap;
    logic [63:0] used;
    string       tag;
  } exp_t;

  exp_t q[$];

  // Reference slot model built from the requirements.
  logic [63:0] m_va [64];
  logic [12:0] m_ctx[64];
  logic [40:0] m_pa [64];
  logic [1:0]  m_sz [64];
  logic [63:0] m_v = '0, m_g = '0, m_p = '0, m_w = '0, m_se = '0, m_so = '0, m_ie = '0;
  logic [63:0] m_used = '0;
  logic [63:0] m_cap = '0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [63:0] va, logic [12:0] ctx, logic [40:0] pa,
                    logic [1:0] sz, bit v, bit g, bit p, bit w, bit se, bit so, bit ie);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_vaddr = va; wr_ctx = ctx; wr_paddr = pa;
    wr_size = sz; wr_valid = v; wr_global = g; wr_priv = p; wr_writable = w;
    wr_side_eff = se; wr_spec_only = so; wr_swap = ie;
    m_va[idx] = va; m_ctx[idx] = ctx; m_pa[idx] = pa; m_sz[idx] = sz;
    m_v[idx] = v; m_g[idx] = g; m_p[idx] = p; m_w[idx] = w;
    m_se[idx] = se; m_so[idx] = so; m_ie[idx] = ie; m_used[idx] = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // kind: 0 load, 1 store, 2 fetch, 3 speculative load
  task automatic lk(logic [63:0] va, logic [12:0] ctx, int kind, bit user, bit trap, string tag);
    exp_t e;
    int   w;
    int   off;
    logic [12:0] lc;
    logic [40:0] m;
    w  = -1;
    lc = (kind == 2 && trap) ? 13'd0 : ctx;
    for (int i = 0; i < 64; i++) begin
      off = 13 + 3 * int'(m_sz[i]);
      if (w < 0 && m_v[i] && (m_g[i] || m_ctx[i] == lc) && ((va >> off) == (m_va[i] >> off)))
        w = i;
    end
    e = '{hit: 0, miss: 0, fault: 0, swap: 0, pr: 0, pw: 0, px: 0, cause: 0,
          pa: 0, entry: 0, cap: 0, used: 0, tag: tag};
    if (w < 0) begin
      e.miss = 1'b1;
      m_cap = {va[63:13], lc};
    end else begin
      e.entry = 6'(w);
      e.cause[0] = m_p[w] && user;
      e.cause[1] = (kind == 3) && m_se[w];
      e.cause[2] = (kind == 0 || kind == 1) && m_so[w];
      e.cause[3] = (kind == 1) && !m_w[w] && (e.cause[2:0] == 3'b000);
      if (e.cause != 4'b0) begin
        e.fault = 1'b1;
        m_cap = {va[63:13], lc};
      end else begin
        e.hit = 1'b1;
        off = 13 + 3 * int'(m_sz[w]);
        m = ~41'd0 << off;
        e.pa = ((m_pa[w] & m) | (va[40:0] & ~m)) & 41'h1ffffffe000;
        e.pr = (kind != 2);
        e.pw = (kind != 2) && m_w[w];
        e.px = (kind == 2);
        e.swap = (kind != 2) && m_ie[w];
        m_used[w] = 1'b1;
      end
    end
    e.cap = m_cap;
    e.used = m_used;
    req_valid = 1'b1; req_vaddr = va; req_ctx = ctx; req_kind = 2'(kind);
    req_user = user; req_trap = trap;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: outputs are registered, so sample at the falling edge.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected response: actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "hit",   64'(rsp_hit),   64'(e.hit));
        chk(e.tag, "miss",  64'(rsp_miss),  64'(e.miss));
        chk(e.tag, "fault", 64'(rsp_fault), 64'(e.fault));
        chk(e.tag, "cause", 64'(rsp_cause), 64'(e.cause));
        chk(e.tag, "paddr", 64'(rsp_paddr), 64'(e.pa));
        chk(e.tag, "perm",  64'({rsp_perm_r, rsp_perm_w, rsp_perm_x}), 64'({e.pr, e.pw, e.px}));
        chk(e.tag, "swap",  64'(rsp_swap),  64'(e.swap));
        if (!e.miss) chk(e.tag, "entry", 64'(rsp_entry), 64'(e.entry));
        chk(e.tag, "capture", tag_capture, e.cap);
        chk(e.tag, "used", used_flags, e.used);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1", "capture", tag_capture, 64'd0);
    chk("R1", "used", used_flags, 64'd0);
    @(negedge clk);
    lk(64'h0000_1234_5678_A000, 13'd5, 0, 0, 0, "R1");

    // R3/R4: 8 KB slot, context 5, writable
    wr(0, 64'h0000_1234_5678_A000, 13'd5, 41'h1_2345_6000, 2'd0, 1, 0, 0, 1, 0, 0, 0);
    lk(64'h0000_1234_5678_A7FC, 13'd5, 0, 1, 0, "R3");
    lk(64'h0000_1234_5678_BFFF, 13'd5, 1, 1, 0, "R3");
    lk(64'h0000_1234_5678_C000, 13'd5, 0, 1, 0, "R3");
    lk(64'h0000_1234_5678_A000, 13'd6, 0, 1, 0, "R4");
    // R4/R9: shared 64 KB read-only byte-swapped slot
    wr(1, 64'hFFFF_FFFF_8000_0000, 13'd9, 41'h0_0ABC_0000, 2'd1, 1, 1, 0, 0, 0, 0, 1);
    lk(64'hFFFF_FFFF_8000_E123, 13'd3, 0, 0, 0, "R4");
    lk(64'hFFFF_FFFF_8001_0000, 13'd9, 0, 0, 0, "R3");
    // R3: 512 KB and 4 MB slots
    wr(2, 64'h0000_0040_0000_0000, 13'd7, 41'h1_FF80_0000, 2'd2, 1, 0, 0, 1, 0, 0, 0);
    lk(64'h0000_0040_0007_E000, 13'd7, 1, 0, 0, "R3");
    lk(64'h0000_0040_0008_0000, 13'd7, 1, 0, 0, "R3");
    wr(3, 64'h0000_0080_0000_0000, 13'd7, 41'h0_5540_0000, 2'd3, 1, 0, 0, 1, 0, 0, 0);
    lk(64'h0000_0080_003F_F000, 13'd7, 0, 0, 0, "R3");
    lk(64'h0000_0080_0040_0000, 13'd7, 0, 0, 0, "R3");

    // R6/R12: overlapping slots, lowest index wins
    wr(20, 64'h0000_0000_1000_0000, 13'd2, 41'h0_0001_0000, 2'd0, 1, 0, 0, 1, 0, 0, 0);
    wr(21, 64'h0000_0000_1000_0000, 13'd2, 41'h0_0002_0000, 2'd0, 1, 0, 0, 1, 0, 0, 0);
    lk(64'h0000_0000_1000_0010, 13'd2, 0, 0, 0, "R6");
    wr(20, 64'h0000_0000_1000_0000, 13'd2, 41'h0_0001_0000, 2'd0, 0, 0, 0, 1, 0, 0, 0);
    lk(64'h0000_0000_1000_0010, 13'd2, 0, 0, 0, "R12");
    wr(30, 64'h0000_0000_2000_0000, 13'd2, 41'h0_0400_0000, 2'd3, 1, 0, 0, 1, 0, 0, 0);
    wr(31, 64'h0000_0000_2010_0000, 13'd2, 41'h0_0800_0000, 2'd0, 1, 0, 0, 1, 0, 0, 0);
    lk(64'h0000_0000_2010_0000, 13'd2, 0, 0, 0, "R6");

    // R7/R8: fault causes
    wr(40, 64'h0000_0000_3000_0000, 13'd1, 41'h0_1000_0000, 2'd0, 1, 0, 1, 1, 1, 0, 0);
    lk(64'h0000_0000_3000_0000, 13'd1, 3, 1, 0, "R7");
    lk(64'h0000_0000_3000_0000, 13'd1, 3, 0, 0, "R7");
    lk(64'h0000_0000_3000_0000, 13'd1, 1, 1, 0, "R7");
    lk(64'h0000_0000_3000_0000, 13'd1, 0, 0, 0, "R10");
    wr(41, 64'h0000_0000_3100_0000, 13'd1, 41'h0_1100_0000, 2'd0, 1, 0, 0, 0, 0, 1, 0);
    lk(64'h0000_0000_3100_0000, 13'd1, 1, 0, 0, "R8");
    lk(64'h0000_0000_3100_0000, 13'd1, 3, 0, 0, "R7");
    wr(42, 64'h0000_0000_3200_0000, 13'd1, 41'h0_1200_0000, 2'd0, 1, 0, 0, 0, 0, 0, 1);
    lk(64'h0000_0000_3200_0000, 13'd1, 1, 0, 0, "R8");
    lk(64'h0000_0000_3200_0000, 13'd1, 0, 0, 0, "R9");
    lk(64'h0000_0000_3200_0000, 13'd1, 2, 1, 0, "R9");
    wr(43, 64'h0000_0000_3300_0000, 13'd1, 41'h0_1300_0000, 2'd0, 1, 0, 1, 0, 0, 0, 0);
    lk(64'h0000_0000_3300_0000, 13'd1, 2, 1, 0, "R7");
    lk(64'h0000_0000_3300_0000, 13'd1, 2, 0, 0, "R9");

    // R5: fetch context selection
    wr(50, 64'h0000_0000_4000_0000, 13'd0, 41'h0_1400_0000, 2'd0, 1, 0, 0, 0, 0, 0, 0);
    wr(51, 64'h0000_0000_4100_0000, 13'd12, 41'h0_1500_0000, 2'd0, 1, 0, 0, 0, 0, 0, 0);
    lk(64'h0000_0000_4000_0000, 13'd12, 2, 0, 1, "R5");
    lk(64'h0000_0000_4000_0000, 13'd12, 2, 0, 0, "R5");
    lk(64'h0000_0000_4000_0000, 13'd12, 0, 0, 1, "R5");
    lk(64'h0000_0000_4100_0000, 13'd12, 2, 0, 0, "R5");
    lk(64'h0000_0000_4100_0000, 13'd12, 2, 0, 1, "R11");

    // R10: rewriting a used slot clears its flag
    wr(0, 64'h0000_1234_5678_A000, 13'd5, 41'h1_2345_6000, 2'd0, 1, 0, 0, 1, 0, 0, 0);
    lk(64'h0000_0000_5000_0000, 13'd5, 0, 0, 0, "R10");

    repeat (3) @(negedge clk);
    chk("R2", "pending", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule